// File: doc/BRIEF.md
# Aliased Register Last-Writer Table

This block records, for every architectural register, the tag of the youngest in-flight instruction that writes it. The registers can overlap. A narrow register can be an alias of a wider one, so the table keeps a small alias description for each register. That description holds a rename target, a set of contained (narrower) registers and a set of containing (wider) registers. Software or a boot sequencer loads the description through a configuration port.

A rename stage sends one write per cycle. Each write carries a register id, an instruction tag and a flag that says whether the write zeroes the wider registers around it. A write to a narrow alias is steered to its rename target. When that steered write keeps the upper bits, the table reports a false dependency on the instruction that currently owns the target. The commit side sends one retire per cycle. A retire clears only the entries that still name the retiring tag.

A source-operand lookup returns the distinct producer tags of the register and of its narrower aliases. The result is a slot bitmask with a tag per slot, and it is available in the same cycle.

Top module: `alias_writer_table`

## Requirements
- R1: After reset every entry is invalid. Every lookup returns an all-zero slot mask, and `dep_valid` is 0.
- R2: A configuration load updates the rename target, the narrower-alias mask and the wider-alias mask of `cfg_reg` from the next cycle on. In each mask, bit i stands for register i. Bit 0 of a mask is discarded, and a load aimed at register 0 is discarded. Each mask holds at most MAX_SUB (narrower) or MAX_SUP (wider) set bits.
- R3: A write's target is its rename target when that target is nonzero and differs from the written register. Otherwise the target is the written register itself.
- R4: A write stores its tag as a valid entry in the target and in every narrower alias of the target.
- R5: The wider aliases of the target take the tag only when `wr_clr_sup` is 1. Otherwise they keep their previous contents.
- R6: `dep_valid` is 1 in the same cycle exactly when all four of these hold: the write is redirected, `wr_clr_sup` is 0, the target entry is valid, and the target entry holds a tag different from `wr_tag`. In that case `dep_tag` gives the target's tag.
- R7: A retire computes its entry set the same way a write does. It invalidates only those entries in the set that are valid and hold `rt_tag`.
- R8: When a write and a retire touch the same entry in one cycle, the write's tag is stored and the entry stays valid.
- R9: Lookup slot 0 is the register itself. Slot k (k ≥ 1) is the k-th lowest-numbered narrower alias. A slot is set when its entry is valid and its tag does not already appear in a lower set slot. The lookup is combinational on the table state.
- R10: A write or retire that names register 0 changes no entry and raises no dependency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load alias description |
| cfg_reg | input | REG_W | Register being configured |
| cfg_rename | input | REG_W | Rename target |
| cfg_sub | input | NUM_REGS | Narrower-alias mask |
| cfg_sup | input | NUM_REGS | Wider-alias mask |
| wr_en | input | 1 | Write request |
| wr_reg | input | REG_W | Destination register |
| wr_tag | input | TAG_W | Writing instruction tag |
| wr_clr_sup | input | 1 | Write zeroes wider aliases |
| dep_valid | output | 1 | False dependency present |
| dep_tag | output | TAG_W | Tag of the prior owner |
| rt_en | input | 1 | Retire request |
| rt_reg | input | REG_W | Retiring destination register |
| rt_tag | input | TAG_W | Retiring instruction tag |
| rt_clr_sup | input | 1 | Retiring write zeroed wider aliases |
| lk_reg | input | REG_W | Source register to look up |
| lk_mask | output | MAX_SUB+1 | Set slots of the lookup |
| lk_tags | output | (MAX_SUB+1)*TAG_W | Tag of each slot |

## Verification
A wrong entry does not show at any port until a lookup covers that register or one of its wider aliases, or until a steered write reads it through `dep_tag`. The bench therefore looks up one register in every cycle and compares all dependency outputs in every cycle. A stale or lost tag then shows up within the cycles that a random lookup needs to land on the register. Directed sequences cover each case without waiting for a random lookup: steering, partial-versus-clearing writes, tag-matched retires, write/retire collisions and register 0.

// File: rtl/arlw_pkg.sv
`timescale 1ns/1ps
package arlw_pkg;
   localparam int ARLW_DEF_REGS  = 16;
   localparam int ARLW_DEF_TAG_W = 6;
   localparam int ARLW_DEF_ALIAS = 4;
endpackage

// File: rtl/arlw_cfg_table.sv
`timescale 1ns/1ps
module arlw_cfg_table #(
   parameter int NUM_REGS = 16,
   parameter int MAX_SUB  = 4,
   parameter int MAX_SUP  = 4,
   parameter int REG_W    = $clog2(NUM_REGS)
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               cfg_we,
   input  logic [REG_W-1:0]                   cfg_reg,
   input  logic [REG_W-1:0]                   cfg_rename,
   input  logic [NUM_REGS-1:0]                cfg_sub,
   input  logic [NUM_REGS-1:0]                cfg_sup,
   output logic [NUM_REGS-1:0][REG_W-1:0]     ren_o,
   output logic [NUM_REGS-1:0][NUM_REGS-1:0]  sub_o,
   output logic [NUM_REGS-1:0][NUM_REGS-1:0]  sup_o
);
   localparam logic [NUM_REGS-1:0] KEEP = {{(NUM_REGS-1){1'b1}}, 1'b0};

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_row
      if (g == 0) begin : g_null
         assign ren_o[g] = '0;
         assign sub_o[g] = '0;
         assign sup_o[g] = '0;
      end else begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ren_o[g] <= '0;
               sub_o[g] <= '0;
               sup_o[g] <= '0;
            end else if (cfg_we && cfg_reg == REG_W'(g)) begin
               ren_o[g] <= cfg_rename;
               sub_o[g] <= cfg_sub & KEEP;
               sup_o[g] <= cfg_sup & KEEP;
            end
         end
      end
   end

   // R2
   alias_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |-> ($countones(cfg_sub & KEEP) <= MAX_SUB) &&
                 ($countones(cfg_sup & KEEP) <= MAX_SUP));
endmodule

// File: rtl/arlw_scope.sv
`timescale 1ns/1ps
module arlw_scope #(
   parameter int NUM_REGS = 16,
   parameter int REG_W    = $clog2(NUM_REGS)
) (
   input  logic                              en,
   input  logic [REG_W-1:0]                  reg_id,
   input  logic                              clr_sup,
   input  logic [NUM_REGS-1:0][REG_W-1:0]    ren,
   input  logic [NUM_REGS-1:0][NUM_REGS-1:0] sub,
   input  logic [NUM_REGS-1:0][NUM_REGS-1:0] sup,
   output logic [REG_W-1:0]                  tgt,
   output logic [NUM_REGS-1:0]               hit
);
   logic [REG_W-1:0] alias_to;

   always_comb begin
      alias_to = ren[reg_id];
      tgt      = (alias_to != '0 && alias_to != reg_id) ? alias_to : reg_id;
      hit      = '0;
      if (en && reg_id != '0) begin
         hit      = sub[tgt];
         hit[tgt] = 1'b1;
         if (clr_sup) hit = hit | sup[tgt];
      end
   end
endmodule

// File: rtl/arlw_entry_array.sv
`timescale 1ns/1ps
module arlw_entry_array #(
   parameter int NUM_REGS = 16,
   parameter int TAG_W    = 6
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_REGS-1:0]            wr_hit,
   input  logic [TAG_W-1:0]               wr_tag,
   input  logic [NUM_REGS-1:0]            rt_hit,
   input  logic [TAG_W-1:0]               rt_tag,
   output logic [NUM_REGS-1:0]            vld_q,
   output logic [NUM_REGS-1:0][TAG_W-1:0] tag_q
);
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[g] <= 1'b0;
            tag_q[g] <= '0;
         end else if (wr_hit[g]) begin
            vld_q[g] <= 1'b1;
            tag_q[g] <= wr_tag;
         end else if (rt_hit[g] && vld_q[g] && tag_q[g] == rt_tag) begin
            vld_q[g] <= 1'b0;
         end
      end

      // R4
      wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wr_hit[g] |=> vld_q[g] && tag_q[g] == $past(wr_tag));

      // R7
      rt_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(vld_q[g]) |-> $past(rt_hit[g]) && $past(tag_q[g]) == $past(rt_tag));
   end
endmodule

// File: rtl/arlw_lookup_merge.sv
`timescale 1ns/1ps
module arlw_lookup_merge #(
   parameter int NUM_REGS = 16,
   parameter int TAG_W    = 6,
   parameter int MAX_SUB  = 4,
   parameter int REG_W    = $clog2(NUM_REGS),
   parameter int SLOTS    = MAX_SUB + 1
) (
   input  logic [REG_W-1:0]               lk_reg,
   input  logic [NUM_REGS-1:0]            lk_sub,
   input  logic [NUM_REGS-1:0]            vld,
   input  logic [NUM_REGS-1:0][TAG_W-1:0] tag,
   output logic [SLOTS-1:0]               mask,
   output logic [SLOTS-1:0][TAG_W-1:0]    tags
);
   logic [SLOTS-1:0][REG_W-1:0] slot_reg;
   logic [SLOTS-1:0]            slot_use;
   logic [SLOTS-1:0]            raw;

   always_comb begin
      int k;
      slot_reg    = '0;
      slot_use    = '0;
      slot_reg[0] = lk_reg;
      slot_use[0] = 1'b1;
      k = 1;
      for (int r = 0; r < NUM_REGS; r++) begin
         if (lk_sub[r] && k < SLOTS) begin
            slot_reg[k] = REG_W'(r);
            slot_use[k] = 1'b1;
            k = k + 1;
         end
      end
   end

   always_comb begin
      logic dup;
      for (int s = 0; s < SLOTS; s++) begin
         raw[s]  = slot_use[s] && vld[slot_reg[s]];
         tags[s] = tag[slot_reg[s]];
      end
      for (int s = 0; s < SLOTS; s++) begin
         dup = 1'b0;
         for (int p = 0; p < s; p++)
            if (mask[p] && tags[p] == tags[s]) dup = 1'b1;
         mask[s] = raw[s] && !dup;
      end
   end
endmodule

// File: rtl/alias_writer_table.sv
`timescale 1ns/1ps
module alias_writer_table #(
   parameter int NUM_REGS = arlw_pkg::ARLW_DEF_REGS,
   parameter int TAG_W    = arlw_pkg::ARLW_DEF_TAG_W,
   parameter int MAX_SUB  = arlw_pkg::ARLW_DEF_ALIAS,
   parameter int MAX_SUP  = arlw_pkg::ARLW_DEF_ALIAS,
   parameter int REG_W    = $clog2(NUM_REGS),
   parameter int SLOTS    = MAX_SUB + 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_we,
   input  logic [REG_W-1:0]             cfg_reg,
   input  logic [REG_W-1:0]             cfg_rename,
   input  logic [NUM_REGS-1:0]          cfg_sub,
   input  logic [NUM_REGS-1:0]          cfg_sup,
   input  logic                         wr_en,
   input  logic [REG_W-1:0]             wr_reg,
   input  logic [TAG_W-1:0]             wr_tag,
   input  logic                         wr_clr_sup,
   output logic                         dep_valid,
   output logic [TAG_W-1:0]             dep_tag,
   input  logic                         rt_en,
   input  logic [REG_W-1:0]             rt_reg,
   input  logic [TAG_W-1:0]             rt_tag,
   input  logic                         rt_clr_sup,
   input  logic [REG_W-1:0]             lk_reg,
   output logic [SLOTS-1:0]             lk_mask,
   output logic [SLOTS-1:0][TAG_W-1:0]  lk_tags
);
   if (NUM_REGS < 4 || (1 << REG_W) < NUM_REGS) begin : g_bad_regs
      $error("alias_writer_table: NUM_REGS/REG_W inconsistent");
   end
   if (MAX_SUB < 1 || MAX_SUB >= NUM_REGS || MAX_SUP < 1 || MAX_SUP >= NUM_REGS) begin : g_bad_alias
      $error("alias_writer_table: alias limits out of range");
   end
   if (TAG_W < 1 || SLOTS != MAX_SUB + 1) begin : g_bad_tag
      $error("alias_writer_table: TAG_W or SLOTS illegal");
   end

   logic [NUM_REGS-1:0][REG_W-1:0]    ren;
   logic [NUM_REGS-1:0][NUM_REGS-1:0] sub;
   logic [NUM_REGS-1:0][NUM_REGS-1:0] sup;
   logic [REG_W-1:0]                  wr_tgt, rt_tgt;
   logic [NUM_REGS-1:0]               wr_hit, rt_hit;
   logic [NUM_REGS-1:0]               ent_vld;
   logic [NUM_REGS-1:0][TAG_W-1:0]    ent_tag;
   logic                              wr_redir;

   arlw_cfg_table #(.NUM_REGS(NUM_REGS), .MAX_SUB(MAX_SUB), .MAX_SUP(MAX_SUP), .REG_W(REG_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_reg(cfg_reg),
      .cfg_rename(cfg_rename), .cfg_sub(cfg_sub), .cfg_sup(cfg_sup),
      .ren_o(ren), .sub_o(sub), .sup_o(sup));

   arlw_scope #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_wr_scope (
      .en(wr_en), .reg_id(wr_reg), .clr_sup(wr_clr_sup),
      .ren(ren), .sub(sub), .sup(sup), .tgt(wr_tgt), .hit(wr_hit));

   arlw_scope #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_rt_scope (
      .en(rt_en), .reg_id(rt_reg), .clr_sup(rt_clr_sup),
      .ren(ren), .sub(sub), .sup(sup), .tgt(rt_tgt), .hit(rt_hit));

   arlw_entry_array #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_ent (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_tag(wr_tag),
      .rt_hit(rt_hit), .rt_tag(rt_tag), .vld_q(ent_vld), .tag_q(ent_tag));

   arlw_lookup_merge #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .MAX_SUB(MAX_SUB),
                       .REG_W(REG_W), .SLOTS(SLOTS)) u_merge (
      .lk_reg(lk_reg), .lk_sub(sub[lk_reg]), .vld(ent_vld), .tag(ent_tag),
      .mask(lk_mask), .tags(lk_tags));

   assign wr_redir  = (wr_tgt != wr_reg);
   assign dep_tag   = ent_tag[wr_tgt];
   assign dep_valid = wr_en && (wr_reg != '0) && wr_redir && !wr_clr_sup &&
                      ent_vld[wr_tgt] && (ent_tag[wr_tgt] != wr_tag);

   // R6
   dep_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dep_valid |-> wr_en && !wr_clr_sup && wr_hit[wr_tgt] && wr_tgt != wr_reg);

   // R7
   rt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rt_hit[rt_tgt] && ent_vld[rt_tgt] && ent_tag[rt_tgt] == rt_tag && !wr_hit[rt_tgt])
      |=> !ent_vld[$past(rt_tgt)]);

   for (genvar i = 0; i < SLOTS; i++) begin : g_dup_i
      for (genvar j = i + 1; j < SLOTS; j++) begin : g_dup_j
         // R9
         slot_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lk_mask[i] && lk_mask[j]) |-> lk_tags[i] != lk_tags[j]);
      end
   end
endmodule

// File: tb/alias_writer_table_tb.sv
`timescale 1ns/1ps
module alias_writer_table_tb;
   localparam int NR = 16;
   localparam int TW = 6;
   localparam int NS = 5;

   logic clk = 0, rst_n = 0;
   logic cfg_we = 0; logic [3:0] cfg_reg = 0, cfg_rename = 0;
   logic [NR-1:0] cfg_sub = 0, cfg_sup = 0;
   logic wr_en = 0, wr_clr_sup = 0, rt_en = 0, rt_clr_sup = 0;
   logic [3:0] wr_reg = 0, rt_reg = 0, lk_reg = 0;
   logic [TW-1:0] wr_tag = 0, rt_tag = 0;
   logic dep_valid; logic [TW-1:0] dep_tag;
   logic [NS-1:0] lk_mask; logic [NS-1:0][TW-1:0] lk_tags;

   alias_writer_table u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_reg(cfg_reg), .cfg_rename(cfg_rename),
      .cfg_sub(cfg_sub), .cfg_sup(cfg_sup), .wr_en(wr_en), .wr_reg(wr_reg), .wr_tag(wr_tag),
      .wr_clr_sup(wr_clr_sup), .dep_valid(dep_valid), .dep_tag(dep_tag), .rt_en(rt_en),
      .rt_reg(rt_reg), .rt_tag(rt_tag), .rt_clr_sup(rt_clr_sup), .lk_reg(lk_reg),
      .lk_mask(lk_mask), .lk_tags(lk_tags));

   always #2.5 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit m_vld [NR]; int m_tag [NR]; int m_ren [NR];
   logic [NR-1:0] m_sub [NR]; logic [NR-1:0] m_sup [NR];

   task automatic check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int tgt_of(int r);
      return (m_ren[r] != 0 && m_ren[r] != r) ? m_ren[r] : r;
   endfunction

   function automatic logic [NR-1:0] set_of(bit en, int r, bit clr);
      logic [NR-1:0] s = '0;
      int t = tgt_of(r);
      if (en && r != 0) begin
         s = m_sub[t];
         s[t] = 1'b1;
         if (clr) s = s | m_sup[t];
      end
      return s;
   endfunction

   task automatic cfg(int r, int rn, logic [NR-1:0] sb, logic [NR-1:0] sp);
      @(negedge clk);
      wr_en = 0; rt_en = 0; cfg_we = 1; cfg_reg = 4'(r); cfg_rename = 4'(rn);
      cfg_sub = sb; cfg_sup = sp;
      @(posedge clk);
      if (r != 0) begin
         m_ren[r] = rn; m_sub[r] = sb & ~16'h1; m_sup[r] = sp & ~16'h1;
      end
   endtask

   task automatic cyc(string req, bit we, int wr, int wt, bit wc,
                      bit re, int rr, int rtg, bit rc, int lr);
      logic [NR-1:0] ws, rs;
      bit exp_dep; int t, k;
      logic [NS-1:0] em; int et [NS]; int sr [NS]; bit su [NS]; bit dup;
      @(negedge clk);
      cfg_we = 0;
      wr_en = we; wr_reg = 4'(wr); wr_tag = TW'(wt); wr_clr_sup = wc;
      rt_en = re; rt_reg = 4'(rr); rt_tag = TW'(rtg); rt_clr_sup = rc; lk_reg = 4'(lr);
      #1;
      t = tgt_of(wr);
      exp_dep = we && wr != 0 && t != wr && !wc && m_vld[t] && m_tag[t] != wt;
      check(dep_valid == exp_dep, {req, " R6 dep_valid"}, int'(dep_valid), int'(exp_dep));
      if (exp_dep) check(int'(dep_tag) == m_tag[t], {req, " R6 dep_tag"}, int'(dep_tag), m_tag[t]);
      for (int s = 0; s < NS; s++) begin su[s] = 0; sr[s] = 0; end
      sr[0] = lr; su[0] = 1; k = 1;
      for (int r = 0; r < NR; r++) if (m_sub[lr][r] && k < NS) begin sr[k] = r; su[k] = 1; k++; end
      for (int s = 0; s < NS; s++) begin
         et[s] = m_tag[sr[s]];
         dup = 0;
         for (int p = 0; p < s; p++) if (em[p] && et[p] == et[s]) dup = 1;
         em[s] = su[s] && m_vld[sr[s]] && !dup;
      end
      check(lk_mask == em, {req, " R9 mask"}, int'(lk_mask), int'(em));
      for (int s = 0; s < NS; s++)
         if (em[s]) check(int'(lk_tags[s]) == et[s], {req, " R9 tag"}, int'(lk_tags[s]), et[s]);
      ws = set_of(we, wr, wc);
      rs = set_of(re, rr, rc);
      @(posedge clk);
      for (int i = 0; i < NR; i++) begin
         if (ws[i]) begin m_vld[i] = 1; m_tag[i] = wt; end
         else if (rs[i] && m_vld[i] && m_tag[i] == rtg) m_vld[i] = 0;
      end
   endtask

   initial begin
      #(5.0 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'd20240611);
      for (int i = 0; i < NR; i++) begin m_vld[i] = 0; m_tag[i] = 0; m_ren[i] = 0; m_sub[i] = 0; m_sup[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      // R1: empty table after reset
      for (int r = 0; r < NR; r++) cyc("R1", 0, 0, 0, 0, 0, 0, 0, 0, r);
      // R2: alias descriptions
      cfg(8, 0, 16'h0600, 16'h0000);
      cfg(9, 8, 16'h0400, 16'h0100);
      cfg(10, 8, 16'h0000, 16'h0300);
      cfg(11, 0, 16'h0001, 16'h0100);
      cfg(12, 12, 16'h0000, 16'h0000);
      // R4: write fills target and narrower aliases, lookup merges duplicates
      cyc("R4", 1, 8, 5, 0, 0, 0, 0, 0, 8);
      cyc("R4", 0, 0, 0, 0, 0, 0, 0, 0, 10);
      // R3 R6: steered partial write, dependency on tag 5
      cyc("R3", 1, 9, 7, 0, 0, 0, 0, 0, 8);
      cyc("R3", 0, 0, 0, 0, 0, 0, 0, 0, 8);
      // R6: same tag gives no dependency; clearing write gives none either
      cyc("R6", 1, 10, 7, 0, 0, 0, 0, 0, 9);
      cyc("R6", 1, 10, 9, 1, 0, 0, 0, 0, 9);
      cyc("R6", 1, 12, 3, 0, 0, 0, 0, 0, 12);
      // R5: wider alias untouched unless clear flag
      cyc("R5", 1, 11, 12, 0, 0, 0, 0, 0, 8);
      cyc("R5", 1, 11, 13, 1, 0, 0, 0, 0, 8);
      cyc("R5", 0, 0, 0, 0, 0, 0, 0, 0, 8);
      // R7: mismatched tag retire keeps entry, matched clears with wider aliases
      cyc("R7", 0, 0, 0, 0, 1, 11, 12, 0, 11);
      cyc("R7", 0, 0, 0, 0, 1, 11, 13, 1, 11);
      cyc("R7", 0, 0, 0, 0, 0, 0, 0, 0, 8);
      // R8: collision, write wins
      cyc("R8", 1, 3, 9, 0, 0, 0, 0, 0, 3);
      cyc("R8", 1, 3, 20, 0, 1, 3, 9, 0, 3);
      cyc("R8", 0, 0, 0, 0, 0, 0, 0, 0, 3);
      // R10: register 0 ignored
      cyc("R10", 1, 0, 33, 1, 0, 0, 0, 0, 0);
      cyc("R10", 0, 0, 0, 0, 1, 0, 20, 1, 0);
      cyc("R10", 0, 0, 0, 0, 0, 0, 0, 0, 3);
      // Random phase
      for (int n = 0; n < 3000; n++) begin
         if ($urandom_range(0, 63) == 0) begin
            logic [NR-1:0] sb, sp;
            sb = '0; sp = '0;
            for (int q = 0; q < 4; q++) begin
               sb[$urandom_range(0, NR-1)] = 1'b1;
               sp[$urandom_range(0, NR-1)] = 1'b1;
            end
            cfg($urandom_range(0, NR-1), $urandom_range(0, 1) ? $urandom_range(0, NR-1) : 0, sb, sp);
         end else begin
            int rr; int rtg;
            rr = $urandom_range(0, NR-1);
            rtg = $urandom_range(0, 3) != 0 ? m_tag[$urandom_range(0, NR-1)] : $urandom_range(0, 63);
            cyc("rand", $urandom_range(0, 9) < 7, $urandom_range(0, NR-1), $urandom_range(0, 63),
                $urandom_range(0, 1), $urandom_range(0, 1), rr, rtg, $urandom_range(0, 1),
                $urandom_range(0, NR-1));
         end
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule